// File: doc/BRIEF.md
# Multidrop Serial Receiver with Address Sleep

This block receives asynchronous serial frames on a single line and hands each received byte to the rest of the chip over a ready/valid port. Every byte carries its parity-error, framing-error and overrun flags. A 16x oversampling clock comes from a programmable divisor. Each bit is decided by a three-sample majority vote taken around the bit centre.

The block is meant for a shared multidrop link. In sleep mode a node keeps only frames whose most significant data bit is 1, which are the address frames. It ignores every other frame silently, so it raises no valid and no overrun for them. Two separate inversion controls are available. One flips the raw line level ahead of all framing logic. The other flips the data bits only as they leave the one-entry receive buffer.

A small write-only configuration port holds the divisor and a control word. Software or a sequencer writes it before traffic starts.

Top module: `uart_addr_rx`

## Requirements
- R1: After reset, the divisor is DEF_DIV (1 gives 16 clocks per bit), all control bits are 0 (parity off, sleep off, line reversal off, data inversion off), and m_valid and m_ovr are low.
- R2: A frame is one low start bit, DATA_W data bits sent least significant bit first, an optional parity bit, and one high stop bit. The byte is presented on m_data with m_valid high, and stays unchanged until a cycle where m_valid and m_ready are both high.
- R3: A start is taken on a falling edge of the corrected line and is confirmed only if the majority of oversamples 7, 8 and 9 is low. A low pulse of 4 clocks at divisor 1 produces no byte.
- R4: With parity enabled (control bit 0), the bit after the data is even parity. m_perr is set when the data bits plus the parity bit hold an odd number of ones.
- R5: A stop bit voted low sets m_ferr on the delivered byte.
- R6: With sleep enabled (control bit 1), a frame whose data MSB is 1 is delivered normally.
- R7: With sleep enabled, a frame whose data MSB is 0 is dropped. It raises neither m_valid nor m_ovr, and it leaves an already held byte untouched.
- R8: With line reversal enabled (control bit 2), the level on rxd is inverted for every bit, idle and stop included, before any detection takes place.
- R9: With data inversion enabled (control bit 3), m_data shows the complement of the stored data bits, while the flags are unchanged. The sleep MSB test uses the data before this inversion.
- R10: If a frame is accepted while the held byte is still unread, the held byte is kept and m_ovr is set on it. m_ovr clears when that byte is read.
- R11: A configuration write to address 0 loads the divisor, so one oversample lasts that many clocks. A write to address 1 loads the control bits from cfg_wdata[3:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rxd | input | 1 | Serial receive line, asynchronous |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 1 | 0 selects the divisor, 1 selects the control bits |
| cfg_wdata | input | DIV_W | Configuration write data |
| m_valid | output | 1 | Received byte is available |
| m_ready | input | 1 | Consumer takes the byte |
| m_data | output | DATA_W | Received data, after optional inversion |
| m_perr | output | 1 | Parity error on this byte |
| m_ferr | output | 1 | Framing error on this byte |
| m_ovr | output | 1 | A later frame was lost while this byte was held |

## Verification
A byte is due a little after the centre of its stop bit. That point is 9.5 bit times after the start edge, plus about four clocks for the two synchronizer stages, the line register and the done pulse.

The bench drives each frame at falling clock edges and follows it with one full idle bit. It samples the outputs at a falling edge after that idle bit, so every result is settled and the next frame cannot have started.

Checks for dropped frames, rejected glitches and polarity switches wait at least as long before they confirm that m_valid stayed low. Expected words are computed from the sent byte, the parity rule and the inversion setting.

// File: rtl/urx_pkg.sv
package urx_pkg;
  localparam logic CFG_DIV_ADDR  = 1'b0;
  localparam logic CFG_CTRL_ADDR = 1'b1;

  typedef struct packed {
    logic data_inv;
    logic line_rev;
    logic sleep_en;
    logic par_en;
  } urx_ctrl_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } urx_state_t;
endpackage

// File: rtl/urx_cfg_regs.sv
module urx_cfg_regs
  import urx_pkg::*;
#(
  parameter int DIV_W   = 16,
  parameter int DEF_DIV = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic             cfg_addr,
  input  logic [DIV_W-1:0] cfg_wdata,
  output logic [DIV_W-1:0] divisor,
  output urx_ctrl_t        ctrl
);
  always_ff @(posedge clk) begin
    if (rst) begin
      divisor <= DIV_W'(DEF_DIV);
      ctrl    <= '0;
    end else if (cfg_we) begin
      if (cfg_addr == CFG_DIV_ADDR) divisor <= cfg_wdata;
      else                          ctrl    <= urx_ctrl_t'(cfg_wdata[3:0]);
    end
  end
endmodule

// File: rtl/urx_line_sampler.sv
module urx_line_sampler #(
  parameter int DIV_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rxd,
  input  logic             line_rev,
  input  logic [DIV_W-1:0] divisor,
  output logic             line,
  output logic             os_tick
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [DIV_W-1:0]       cnt_q;
  logic                   wrap;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '1;
        else     sync_q <= rxd;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '1;
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], rxd};
      end
    end
  endgenerate

  // corrected line level, idle high in both polarities
  always_ff @(posedge clk) begin
    if (rst) line <= 1'b1;
    else     line <= sync_q[SYNC_STAGES-1] ^ line_rev;
  end

  // a divisor of 0 behaves as 1
  assign wrap = ({1'b0, cnt_q} + (DIV_W+1)'(1)) >= {1'b0, divisor};

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      os_tick <= 1'b0;
    end else begin
      os_tick <= wrap;
      cnt_q   <= wrap ? '0 : cnt_q + DIV_W'(1);
    end
  end
endmodule

// File: rtl/urx_framer.sv
module urx_framer
  import urx_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int OS_RATE = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              line,
  input  logic              os_tick,
  input  logic              par_en,
  output logic              done,
  output logic [DATA_W-1:0] data,
  output logic              perr,
  output logic              ferr
);
  localparam int PH_W    = $clog2(OS_RATE);
  localparam int BC_W    = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam int VOTE_PH = OS_RATE / 2 + 1;

  urx_state_t       state_q;
  logic [PH_W-1:0]  phase_q;
  logic [BC_W-1:0]  bitcnt_q;
  logic [1:0]       win_q;
  logic             line_d;
  logic             par_acc_q;
  logic             vote;
  logic             at_vote;
  logic             at_end;

  assign vote    = (win_q[1] & win_q[0]) | (win_q[1] & line) | (win_q[0] & line);
  assign at_vote = os_tick && (phase_q == PH_W'(VOTE_PH));
  assign at_end  = os_tick && (phase_q == PH_W'(OS_RATE - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      phase_q   <= '0;
      bitcnt_q  <= '0;
      win_q     <= 2'b11;
      line_d    <= 1'b1;
      par_acc_q <= 1'b0;
      done      <= 1'b0;
      data      <= '0;
      perr      <= 1'b0;
      ferr      <= 1'b0;
    end else begin
      line_d <= line;
      done   <= 1'b0;
      if (state_q == ST_IDLE) begin
        if (line_d && !line) begin
          state_q   <= ST_START;
          phase_q   <= '0;
          bitcnt_q  <= '0;
          par_acc_q <= 1'b0;
          win_q     <= 2'b11;
        end
      end else if (os_tick) begin
        win_q   <= {win_q[0], line};
        phase_q <= at_end ? '0 : phase_q + PH_W'(1);
        unique case (state_q)
          ST_START: begin
            if (at_vote && vote) state_q <= ST_IDLE;
            else if (at_end)     state_q <= ST_DATA;
          end
          ST_DATA: begin
            if (at_vote) begin
              data      <= {vote, data[DATA_W-1:1]};
              par_acc_q <= par_acc_q ^ vote;
            end
            if (at_end) begin
              if (bitcnt_q == BC_W'(DATA_W - 1)) state_q <= par_en ? ST_PAR : ST_STOP;
              else bitcnt_q <= bitcnt_q + BC_W'(1);
            end
          end
          ST_PAR: begin
            if (at_vote) par_acc_q <= par_acc_q ^ vote;
            if (at_end)  state_q   <= ST_STOP;
          end
          ST_STOP: begin
            if (at_vote) begin
              done    <= 1'b1;
              perr    <= par_en & par_acc_q;
              ferr    <= ~vote;
              state_q <= ST_IDLE;
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/urx_hold.sv
module urx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_done,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_perr,
  input  logic              in_ferr,
  input  logic              sleep_en,
  input  logic              data_inv,
  input  logic              m_ready,
  output logic              m_valid,
  output logic [DATA_W-1:0] m_data,
  output logic              m_perr,
  output logic              m_ferr,
  output logic              m_ovr
);
  logic [DATA_W-1:0] buf_q;
  logic              accept;
  logic              pop;

  // address filter looks at line-corrected data, before read inversion
  assign accept = in_done && (!sleep_en || in_data[DATA_W-1]);
  assign pop    = m_valid && m_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      m_valid <= 1'b0;
      m_ovr   <= 1'b0;
      m_perr  <= 1'b0;
      m_ferr  <= 1'b0;
      buf_q   <= '0;
    end else if (accept && (!m_valid || pop)) begin
      m_valid <= 1'b1;
      m_ovr   <= 1'b0;
      m_perr  <= in_perr;
      m_ferr  <= in_ferr;
      buf_q   <= in_data;
    end else if (accept) begin
      m_ovr <= 1'b1;
    end else if (pop) begin
      m_valid <= 1'b0;
      m_ovr   <= 1'b0;
    end
  end

  assign m_data = buf_q ^ {DATA_W{data_inv}};
endmodule

// File: rtl/uart_addr_rx.sv
module uart_addr_rx
  import urx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int OS_RATE     = 16,
  parameter int DIV_W       = 16,
  parameter int DEF_DIV     = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rxd,
  input  logic              cfg_we,
  input  logic              cfg_addr,
  input  logic [DIV_W-1:0]  cfg_wdata,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [DATA_W-1:0] m_data,
  output logic              m_perr,
  output logic              m_ferr,
  output logic              m_ovr
);
  urx_ctrl_t         ctrl;
  logic [DIV_W-1:0]  divisor;
  logic              line;
  logic              os_tick;
  logic              frm_done;
  logic [DATA_W-1:0] frm_data;
  logic              frm_perr;
  logic              frm_ferr;
  logic              sleep_en;
  logic              data_inv;
  logic              line_rev;

  assign sleep_en = ctrl.sleep_en;
  assign data_inv = ctrl.data_inv;
  assign line_rev = ctrl.line_rev;

  urx_cfg_regs #(.DIV_W(DIV_W), .DEF_DIV(DEF_DIV)) u_cfg (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .divisor(divisor), .ctrl(ctrl)
  );

  urx_line_sampler #(.DIV_W(DIV_W), .SYNC_STAGES(SYNC_STAGES)) u_smp (
    .clk(clk), .rst(rst), .rxd(rxd), .line_rev(line_rev),
    .divisor(divisor), .line(line), .os_tick(os_tick)
  );

  urx_framer #(.DATA_W(DATA_W), .OS_RATE(OS_RATE)) u_frm (
    .clk(clk), .rst(rst), .line(line), .os_tick(os_tick),
    .par_en(ctrl.par_en), .done(frm_done), .data(frm_data),
    .perr(frm_perr), .ferr(frm_ferr)
  );

  urx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst(rst), .in_done(frm_done), .in_data(frm_data),
    .in_perr(frm_perr), .in_ferr(frm_ferr), .sleep_en(sleep_en),
    .data_inv(data_inv), .m_ready(m_ready), .m_valid(m_valid),
    .m_data(m_data), .m_perr(m_perr), .m_ferr(m_ferr), .m_ovr(m_ovr)
  );
endmodule

// File: rtl/urx_chk.sv
module urx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_we,
  input logic              m_valid,
  input logic              m_ready,
  input logic [DATA_W-1:0] m_data,
  input logic              m_perr,
  input logic              m_ferr,
  input logic              m_ovr,
  input logic              sleep_en,
  input logic              data_inv,
  input logic              line_rev
);
  // R1
  rev_reset_chk: assert property (@(posedge clk) rst |=> !line_rev);

  // R2
  hold_valid_chk: assert property (@(posedge clk) disable iff (rst)
    m_valid && !m_ready |=> m_valid);

  // R2
  hold_data_chk: assert property (@(posedge clk) disable iff (rst)
    m_valid && !m_ready && !cfg_we |=> $stable(m_data) && $stable({m_perr, m_ferr}));

  // R10
  ovr_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(m_ovr) |-> $past(m_valid && !m_ready));

  // R10
  ovr_valid_chk: assert property (@(posedge clk) disable iff (rst)
    m_ovr |-> m_valid);

  // R6
  sleep_msb_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(m_valid) && $past(sleep_en) && !data_inv |-> m_data[DATA_W-1]);
endmodule

bind uart_addr_rx urx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .cfg_we(cfg_we), .m_valid(m_valid),
  .m_ready(m_ready), .m_data(m_data), .m_perr(m_perr), .m_ferr(m_ferr),
  .m_ovr(m_ovr), .sleep_en(sleep_en), .data_inv(data_inv),
  .line_rev(line_rev)
);

// File: tb/tb_uart_addr_rx.sv
module tb_uart_addr_rx;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rxd = 1'b1;
  logic        cfg_we = 1'b0;
  logic        cfg_addr = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic        m_valid;
  logic        m_ready = 1'b0;
  logic [7:0]  m_data;
  logic        m_perr, m_ferr, m_ovr;

  int checks = 0;
  int failures = 0;
  logic rev_tb = 1'b0;

  always #2 clk = ~clk;

  uart_addr_rx dut (
    .clk(clk), .rst(rst), .rxd(rxd), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .m_valid(m_valid), .m_ready(m_ready),
    .m_data(m_data), .m_perr(m_perr), .m_ferr(m_ferr), .m_ovr(m_ovr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic a, input logic [15:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic drive(input logic lvl, input int bitc);
    rxd = lvl ^ rev_tb;
    repeat (bitc) @(negedge clk);
  endtask

  // pmode: 0 no parity bit, 1 correct even parity, 2 wrong parity
  task automatic send_frame(input logic [7:0] b, input int pmode, input logic stop, input int bitc);
    drive(1'b0, bitc);
    for (int i = 0; i < 8; i++) drive(b[i], bitc);
    if (pmode != 0) drive((^b) ^ (pmode == 2), bitc);
    drive(stop, bitc);
    drive(1'b1, bitc);
  endtask

  // exp word = {ovr, ferr, perr, data}
  task automatic expect_rx(input string req, input logic exp_v, input logic [10:0] exp_w);
    chk(req, {31'd0, m_valid}, {31'd0, exp_v});
    if (exp_v) chk(req, {21'd0, m_ovr, m_ferr, m_perr, m_data}, {21'd0, exp_w});
    if (m_valid) begin
      m_ready = 1'b1;
      @(negedge clk);
      m_ready = 1'b0;
    end
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1", {30'd0, m_valid, m_ovr}, 32'd0);
    // R1 default divisor and controls, R2 LSB-first delivery and hold
    send_frame(8'hA5, 0, 1'b1, 16);
    repeat (50) @(negedge clk);
    expect_rx("R2", 1'b1, {3'b000, 8'hA5});
    chk("R2", {31'd0, m_valid}, 32'd0);

    // R11 control write: parity on; R4 sweep with correct parity
    cfg_write(1'b1, 16'h0001);
    for (int b = 0; b < 256; b++) begin
      send_frame(8'(b), 1, 1'b1, 16);
      expect_rx("R4", 1'b1, {3'b000, 8'(b)});
    end
    // R4 parity mismatch
    send_frame(8'h3C, 2, 1'b1, 16);
    expect_rx("R4", 1'b1, {3'b001, 8'h3C});
    // R5 low stop bit
    send_frame(8'h81, 1, 1'b0, 16);
    expect_rx("R5", 1'b1, {3'b010, 8'h81});
    // R3 short glitch rejected
    rxd = 1'b0;
    repeat (4) @(negedge clk);
    rxd = 1'b1;
    repeat (100) @(negedge clk);
    expect_rx("R3", 1'b0, '0);
    // R10 overrun keeps older byte
    send_frame(8'h11, 1, 1'b1, 16);
    send_frame(8'h22, 1, 1'b1, 16);
    expect_rx("R10", 1'b1, {3'b100, 8'h11});
    chk("R10", {31'd0, m_valid}, 32'd0);

    // R6 / R7 sleep sweep, parity off
    cfg_write(1'b1, 16'h0002);
    for (int b = 0; b < 256; b++) begin
      send_frame(8'(b), 0, 1'b1, 16);
      expect_rx(b[7] ? "R6" : "R7", b[7], {3'b000, 8'(b)});
    end
    // R7 dropped frame does not overrun held byte
    send_frame(8'h80, 0, 1'b1, 16);
    send_frame(8'h05, 0, 1'b1, 16);
    expect_rx("R7", 1'b1, {3'b000, 8'h80});

    // R8 line reversal, parity on
    rev_tb = 1'b1;
    rxd = 1'b0;
    cfg_write(1'b1, 16'h0005);
    repeat (64) @(negedge clk);
    expect_rx("R8", 1'b0, '0);
    for (int i = 0; i < 64; i++) begin
      send_frame(8'(i * 4 + 1), 1, 1'b1, 16);
      expect_rx("R8", 1'b1, {3'b000, 8'(i * 4 + 1)});
    end
    send_frame(8'h99, 1, 1'b0, 16);
    expect_rx("R8", 1'b1, {3'b010, 8'h99});
    rev_tb = 1'b0;
    rxd = 1'b1;
    cfg_write(1'b1, 16'h0001);
    repeat (64) @(negedge clk);
    expect_rx("R8", 1'b0, '0);

    // R9 read inversion with sleep and parity
    cfg_write(1'b1, 16'h000B);
    send_frame(8'h83, 1, 1'b1, 16);
    expect_rx("R9", 1'b1, {3'b000, 8'h7C});
    send_frame(8'h7F, 1, 1'b1, 16);
    expect_rx("R9", 1'b0, '0);
    send_frame(8'hF0, 2, 1'b1, 16);
    expect_rx("R9", 1'b1, {3'b001, 8'h0F});
    for (int i = 0; i < 32; i++) begin
      send_frame(8'(i * 8 + 3), 1, 1'b1, 16);
      expect_rx("R9", (i >= 16), {3'b000, ~8'(i * 8 + 3)});
    end

    // R11 divisor write: 3 clocks per oversample
    cfg_write(1'b1, 16'h0000);
    cfg_write(1'b0, 16'd3);
    send_frame(8'h5A, 0, 1'b1, 48);
    expect_rx("R11", 1'b1, {3'b000, 8'h5A});
    send_frame(8'hC3, 0, 1'b1, 48);
    expect_rx("R11", 1'b1, {3'b000, 8'hC3});

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule